// File: doc/BRIEF.md
# Configurable-Ratio Serial Lane Deserializer

This block gathers bits from up to ten serial input lanes, clocked at the high-speed rate, into one 40-bit parallel word. A 3-bit ratio select sets two things: how many lanes carry data, and how many bits each lane contributes per word. Every lane fills its own contiguous slice of the output word. The earliest bit received lands in the slice's lowest position.

A boundary strobe from an external timing block marks the first bit of a word and aligns the internal bit counter to it. After that first strobe the counter runs freely and wraps every n cycles, where n is the lane width. A strobe that arrives later restarts the word. A finished word is copied into an output register that does not change for the next n cycles while the following word fills, and a one-cycle flag marks every update. A separate retimer flop, enabled by the low-speed clock enable, copies a control input to its own output.

Top module: `lane_deser`

## Requirements
- R1: `mod_sel` selects lanes × bits-per-lane: 0 → 10×4, 1 → 8×5, 2 → 5×8, 3 → 4×10, 4 → 2×16, 5 → 2×20, 6 → 1×32, 7 → 1×40. The word period n equals the bits-per-lane value W.
- R2: The bit that lane k carries in word cycle t (t = 0 for the strobed first bit) appears at `sb_out[k*W + t]`.
- R3: While the block streams without further strobes, it produces one word every n cycles, and `word_vld` is high for exactly one cycle with each `sb_out` update.
- R4: When `frame_strobe` and the first bit are sampled at rising edge e, the word and `word_vld` appear after rising edge e+n+1. The two input register stages add two cycles to the n-cycle fill.
- R5: `sb_out` holds its value in every cycle in which `word_vld` is low.
- R6: Bits of `sb_out` at or above lanes×W read as 0 (bits 39:32 in modes 4 and 6). Inputs on unused lanes have no effect on the word.
- R7: A `frame_strobe` in the middle of a word discards the partial word, produces no update for it, and restarts filling at t = 0.
- R8: While reset is active, `sb_out`, `word_vld` and `rt_out` are 0. After reset, no word is produced until the first `frame_strobe`.
- R9: On each rising edge with `ls_ce` high, `rt_out` takes `retime_in`. With `ls_ce` low, `rt_out` keeps its value.
- R10: A retimer capture and a word update on the same edge do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_sel | input | 3 | Ratio select (see R1) |
| frame_strobe | input | 1 | Marks the first bit of a word |
| din | input | 10 | Serial lane inputs, one bit per lane per cycle |
| ls_ce | input | 1 | Low-speed clock enable for the retimer |
| retime_in | input | 1 | Retimer data input |
| sb_out | output | 40 | Assembled parallel word |
| word_vld | output | 1 | One-cycle pulse with each word update |
| rt_out | output | 1 | Retimer output |

## Verification
Two things can happen on the same edge: a word update and a retimer capture. The bench forces `ls_ce` high on exactly the edge that loads each checked word. One cycle later it compares both the word and `rt_out` against its own models. A further collision is a strobe arriving while a word is only part-filled. The bench judges it by the absence of any update pulse and by the clean word that follows.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    localparam int WORD_W = 40;                 // parallel word width
    localparam int LANE_N = 10;                 // serial lane count
    localparam int IDX_W  = $clog2(WORD_W);     // bit-position counter width
    localparam int LCNT_W = $clog2(LANE_N + 1); // lane count width

    typedef struct packed {
        logic [LCNT_W-1:0] lanes;
        logic [IDX_W-1:0]  width;
    } geom_t;

    // Ratio select to lane count and bits per lane.
    function automatic geom_t geom_of(input logic [2:0] sel);
        geom_t g;
        case (sel)
            3'd0:    begin g.lanes = LCNT_W'(10); g.width = IDX_W'(4);  end
            3'd1:    begin g.lanes = LCNT_W'(8);  g.width = IDX_W'(5);  end
            3'd2:    begin g.lanes = LCNT_W'(5);  g.width = IDX_W'(8);  end
            3'd3:    begin g.lanes = LCNT_W'(4);  g.width = IDX_W'(10); end
            3'd4:    begin g.lanes = LCNT_W'(2);  g.width = IDX_W'(16); end
            3'd5:    begin g.lanes = LCNT_W'(2);  g.width = IDX_W'(20); end
            3'd6:    begin g.lanes = LCNT_W'(1);  g.width = IDX_W'(32); end
            default: begin g.lanes = LCNT_W'(1);  g.width = IDX_W'(40); end
        endcase
        return g;
    endfunction

    // Number of word bits in use for a ratio select.
    function automatic int active_bits(input logic [2:0] sel);
        geom_t g;
        g = geom_of(sel);
        return int'(g.lanes) * int'(g.width);
    endfunction
endpackage

// File: rtl/sdm_phase.sv
// Bit-position counter. It is idle after reset until the first strobe,
// then wraps every `width` cycles. A strobe forces position 0.
// Assumes width >= 2 and that width does not change in the middle of a word.
module sdm_phase
    import sdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_d,
    input  logic [IDX_W-1:0] width,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic             last
);
    logic             running;
    logic [IDX_W-1:0] cnt;

    // Current write position and end-of-word detect.
    always_comb begin
        idx   = strobe_d ? '0 : cnt;
        wr_en = strobe_d | running;
        last  = wr_en && (idx >= width - IDX_W'(1));
    end

    // Advance the position and arm the counter on the first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else begin
            if (strobe_d) running <= 1'b1;
            if (wr_en)    cnt <= last ? '0 : idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/sdm_gather.sv
// Fill buffer plus output word register, forming a double buffer.
// Lane k writes bit position k*width+idx. The output loads the fully
// merged word on `last`, with unused bit positions forced to zero.
module sdm_gather
    import sdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_N-1:0] lane_bits,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic              last,
    input  logic [LCNT_W-1:0] lanes,
    input  logic [IDX_W-1:0]  width,
    output logic [WORD_W-1:0] word,
    output logic              vld
);
    logic [WORD_W-1:0] fill_q;
    logic [WORD_W-1:0] fill_nx;
    logic [WORD_W-1:0] keep;

    // Merge this cycle's lane bits into the fill buffer; build the in-use mask.
    always_comb begin
        fill_nx = fill_q;
        keep    = '0;
        for (int k = 0; k < LANE_N; k++) begin
            for (int j = 0; j < WORD_W; j++) begin
                if (k < int'(lanes) && j < int'(width) &&
                    (k * int'(width) + j) < WORD_W) begin
                    keep[k * int'(width) + j] = 1'b1;
                    if (j == int'(idx))
                        fill_nx[k * int'(width) + j] = lane_bits[k];
                end
            end
        end
    end

    // Fill buffer update.
    always_ff @(posedge clk) begin
        if (!rst_n)     fill_q <= '0;
        else if (wr_en) fill_q <= fill_nx;
    end

    // Output word and update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= last;
            if (last) word <= fill_nx & keep;
        end
    end
endmodule

// File: rtl/sdm_retime.sv
// Single retiming flop, enabled by the low-speed clock enable.
module sdm_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic d,
    output logic q
);
    // Capture on enable, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (ce) q <= d;
    end
endmodule

// File: rtl/lane_deser.sv
// Serial lanes to parallel word. Inputs pass two register stages, then
// the phase counter steers each lane bit into the fill buffer.
// Assumes mod_sel is changed only between words.
module lane_deser
    import sdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mod_sel,
    input  logic              frame_strobe,
    input  logic [LANE_N-1:0] din,
    input  logic              ls_ce,
    input  logic              retime_in,
    output logic [WORD_W-1:0] sb_out,
    output logic              word_vld,
    output logic              rt_out
);
    logic [LANE_N-1:0] din_s1, din_s2;
    logic              stb_s1, stb_s2;
    geom_t             geo;
    logic [IDX_W-1:0]  idx;
    logic              wr_en, last;

    // Decode the ratio select.
    always_comb geo = geom_of(mod_sel);

    // Two input register stages for lanes and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_s1 <= '0; din_s2 <= '0;
            stb_s1 <= 1'b0; stb_s2 <= 1'b0;
        end else begin
            din_s1 <= din;    din_s2 <= din_s1;
            stb_s1 <= frame_strobe; stb_s2 <= stb_s1;
        end
    end

    sdm_phase u_phase (
        .clk(clk), .rst_n(rst_n), .strobe_d(stb_s2), .width(geo.width),
        .idx(idx), .wr_en(wr_en), .last(last)
    );

    sdm_gather u_gather (
        .clk(clk), .rst_n(rst_n), .lane_bits(din_s2), .idx(idx),
        .wr_en(wr_en), .last(last), .lanes(geo.lanes), .width(geo.width),
        .word(sb_out), .vld(word_vld)
    );

    sdm_retime u_rt (
        .clk(clk), .rst_n(rst_n), .ce(ls_ce), .d(retime_in), .q(rt_out)
    );
endmodule

// File: rtl/lane_deser_chk.sv
// Property checker for lane_deser, bound to every instance.
module lane_deser_chk
    import sdm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mod_sel,
    input logic              frame_strobe,
    input logic              ls_ce,
    input logic              retime_in,
    input logic [WORD_W-1:0] sb_out,
    input logic              word_vld,
    input logic              rt_out
);
    logic       seen;
    logic [2:0] sel_d;
    int         act;

    // Track whether a strobe has occurred and the ratio used at the last load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            sel_d <= 3'd0;
        end else begin
            if (frame_strobe) seen <= 1'b1;
            sel_d <= mod_sel;
        end
    end

    // Bits in use for the ratio that loaded the current word.
    always_comb act = active_bits(sel_d);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(sb_out));
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ((sb_out >> act) == '0));
    a_r8_quiet_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !word_vld);
    a_r9_rt_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ls_ce |=> (rt_out == $past(retime_in)));
    a_r9_rt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_ce |=> $stable(rt_out));
endmodule

bind lane_deser lane_deser_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .frame_strobe(frame_strobe),
    .ls_ce(ls_ce), .retime_in(retime_in), .sb_out(sb_out),
    .word_vld(word_vld), .rt_out(rt_out)
);

// File: tb/sim_lane_deser.sv
module sim_lane_deser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mod_sel = 3'd0;
    logic        frame_strobe = 1'b0;
    logic [9:0]  din = '0;
    logic        ls_ce = 1'b0;
    logic        retime_in = 1'b0;
    logic [39:0] sb_out;
    logic        word_vld;
    logic        rt_out;

    int total = 0;
    int bad = 0;
    int lanes_m, width_m;
    logic        rt_model = 1'b0;
    logic [39:0] hold_exp = '0;
    bit          done = 1'b0;

    lane_deser u0 (
        .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .frame_strobe(frame_strobe),
        .din(din), .ls_ce(ls_ce), .retime_in(retime_in), .sb_out(sb_out),
        .word_vld(word_vld), .rt_out(rt_out)
    );

    always #2 clk = ~clk;

    // Ratio select and word pattern, one per select code.
    localparam logic [42:0] VEC [8] = '{
        {3'd0, 40'hA5_3C_96_0F_E1},
        {3'd1, 40'h12_34_56_78_9A},
        {3'd2, 40'hFE_DC_BA_98_76},
        {3'd3, 40'h00_00_00_00_01},
        {3'd4, 40'hFF_80_00_00_01},
        {3'd5, 40'h80_00_00_00_00},
        {3'd6, 40'hC3_DE_AD_BE_EF},
        {3'd7, 40'h5A_F0_0F_33_CC}
    };

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Lane geometry as stated in R1, restated here on the bench side.
    task automatic set_mode(input logic [2:0] m);
        mod_sel = m;
        case (m)
            3'd0: begin lanes_m = 10; width_m = 4;  end
            3'd1: begin lanes_m = 8;  width_m = 5;  end
            3'd2: begin lanes_m = 5;  width_m = 8;  end
            3'd3: begin lanes_m = 4;  width_m = 10; end
            3'd4: begin lanes_m = 2;  width_m = 16; end
            3'd5: begin lanes_m = 2;  width_m = 20; end
            3'd6: begin lanes_m = 1;  width_m = 32; end
            default: begin lanes_m = 1; width_m = 40; end
        endcase
    endtask

    function automatic logic [39:0] expect_word(input logic [39:0] w);
        logic [39:0] m;
        m = '0;
        for (int b = 0; b < 40; b++) if (b < lanes_m * width_m) m[b] = 1'b1;
        return w & m;
    endfunction

    // Drive nbits cycles of word w. If chk_en is set, the previous word is
    // checked at t == 2, which follows edge e+n+1 of that word (R4).
    task automatic send(input logic [39:0] w, input bit strobe, input int nbits,
                        input bit chk_en, input logic [39:0] chk_exp);
        for (int t = 0; t < nbits; t++) begin
            @(negedge clk);
            if (chk_en && t == 2) begin
                chk(word_vld == 1'b1, "R3/R4 word_vld pulse", 40'(word_vld), 40'd1);
                chk(sb_out == chk_exp, "R1/R2/R6 word content", sb_out, chk_exp);
                chk(rt_out == rt_model, "R10 retimer at word update", 40'(rt_out), 40'(rt_model));
                hold_exp = chk_exp;
            end else begin
                chk(word_vld == 1'b0, "R3/R4/R7 no extra pulse", 40'(word_vld), 40'd0);
                chk(sb_out == hold_exp, "R5 word held", sb_out, hold_exp);
                chk(rt_out == rt_model, "R9 retimer", 40'(rt_out), 40'(rt_model));
            end
            ls_ce = (chk_en && t == 1) ? 1'b1 : 1'($urandom);
            retime_in = 1'($urandom);
            if (ls_ce) rt_model = retime_in;
            for (int k = 0; k < 10; k++)
                din[k] = (k < lanes_m) ? w[k * width_m + t] : 1'($urandom);
            frame_strobe = strobe && (t == 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 40'd0, 40'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_mode(3'd0);
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(sb_out == '0, "R8 reset word", sb_out, '0);
        chk(word_vld == 1'b0, "R8 reset pulse", 40'(word_vld), 40'd0);
        chk(rt_out == 1'b0, "R8 reset retimer", 40'(rt_out), 40'd0);
        rst_n = 1'b1;
        // R8: no word without a strobe
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            chk(word_vld == 1'b0, "R8 quiet before strobe", 40'(word_vld), 40'd0);
            din = 10'($urandom);
        end
        // Vector table: strobed word, free-running second word, flush.
        for (int i = 0; i < 8; i++) begin
            logic [39:0] w;
            set_mode(VEC[i][42:40]);
            w = VEC[i][39:0];
            send(w, 1'b1, width_m, 1'b0, '0);
            send(~w, 1'b0, width_m, 1'b1, expect_word(w));
            send(40'($urandom), 1'b0, 3, 1'b1, expect_word(~w));
        end
        // R7: a strobe in mid-word restarts assembly
        set_mode(3'd3);
        send(40'hFF_FF_FF_FF_FF, 1'b1, 6, 1'b0, '0);
        send(40'h3_1415_9265, 1'b1, width_m, 1'b0, '0);
        send(40'($urandom), 1'b0, 3, 1'b1, expect_word(40'h3_1415_9265));
        // R6: upper bits zero in the 2x16 mode even with ones driven
        set_mode(3'd4);
        send(40'hFF_FF_FF_FF_FF, 1'b1, width_m, 1'b0, '0);
        send(40'($urandom), 1'b0, 3, 1'b1, 40'h00_FF_FF_FF_FF);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule